// File: doc/BRIEF.md
# Autobaud Retimer

The block learns the bit rate of an asynchronous serial line on its own, and then re-clocks the line as a synchronous bit stream. After reset it waits until the line has stayed idle-high for a long training gap. It then times the intervals between the next input transitions and keeps the shortest one as its estimate of one bit period. That estimate is matched against the standard rates from 300 to 9600 bit/s. If a standard rate fits, the block waits for a shorter quiet gap, so that the training character has fully ended, and then locks.

Once locked, the block forwards the line to `data_out` and drives a bit clock and its inverse at the detected rate. Every transition on the input restarts the bit timer, so the output timing follows the sender rather than running free. This lets the block tolerate jittered edges and a small rate mismatch. Framing, start and stop bits, and character assembly belong to the logic downstream.

The default gap lengths correspond to 0.325 s and 40 ms at a 3.6864 MHz clock. Both are parameters, so a simulation can shorten them.

Top module: `autobaud_retimer`

## Requirements
- R1: While reset is held, and directly after it, `locked` is 0, `rate_code` is 0, `bit_clk` is 0, `bit_clk_n` is 1 and `data_out` is 1.
- R2: Training begins only after the synchronised line has been high without a break for `GAP_TRAIN_CYC` cycles. Transitions that arrive before that gap has completed do not affect the detected rate.
- R3: After the gap, the first transition starts a measurement of `NUM_INTERVALS` (8) consecutive inter-transition intervals, and the shortest of these intervals is the one that gets quantised.
- R4: The shortest interval is accepted when it lies within ±1/8 of a nominal period `CLK_HZ/(300·2^k)`. The rate code is then k: 0=300, 1=600, 2=1200, 3=2400, 4=4800, 5=9600 bit/s.
- R5: Training restarts from the gap stage, with `locked` kept low, in either of two cases: the shortest interval fits no rate, or any single interval reaches twice the 300 bit/s nominal period.
- R6: After an accepted measurement, `locked` rises only once the line has been high without a break for `GAP_DATA_CYC` cycles. From then on, `locked` and `rate_code` hold until reset.
- R7: While locked, `bit_clk` rises at each bit start and falls half a nominal period later. At that falling edge, `data_out` takes the synchronised input value. `bit_clk_n` is always the inverse of `bit_clk`. Before lock, `bit_clk` stays 0 and `data_out` stays 1.
- R8: Every synchronised input transition reloads the bit timer. As a result, bits sent up to 1/8 slower than nominal, and individually delayed edges, are still sampled correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the timing reference |
| rst_n | input | 1 | Synchronous reset, active low |
| serial_in | input | 1 | Asynchronous serial line, idles high |
| data_out | output | 1 | Retimed data, updated on the falling edge of `bit_clk` |
| bit_clk | output | 1 | Recovered bit clock, rising at bit start |
| bit_clk_n | output | 1 | Inverse of `bit_clk` |
| rate_code | output | 3 | Detected rate code k, rate = 300·2^k bit/s |
| locked | output | 1 | High once training and the quiet gap have completed |

## Verification
A fault in the training state machine or in the interval minimum shows up as a wrong `rate_code`, or as `locked` never rising. This becomes visible one quiet gap after the training character ends. A fault in the quantiser band edges shows up as a rejected or wrongly coded rate at the same moment. A bit timer that fails to reload on transitions samples the wrong bit within a few bit times of a slow or skewed input. That appears at the first `bit_clk` falling edge that lands in the neighbouring bit.

// File: rtl/abr_pkg.sv
// Shared constants, types and the nominal-period computation for the autobaud retimer.
package abr_pkg;

    localparam int RATE_CNT = 6;
    localparam int CODE_W   = 3;

    typedef logic [CODE_W-1:0] rate_code_t;

    typedef enum logic [2:0] {
        TR_GAP1,
        TR_ARMED,
        TR_MEAS,
        TR_QUANT,
        TR_GAP2,
        TR_LOCK
    } tr_state_e;

    // Clock cycles per bit for rate code k, where the rate is base_rate doubled k times.
    function automatic int unsigned nominal_cycles(input int unsigned clk_hz,
                                                   input int unsigned base_rate,
                                                   input int unsigned code);
        return clk_hz / (base_rate << code);
    endfunction

endpackage

// File: rtl/abr_sync_edge.sv
// Synchroniser and transition detector for the serial input.
// Assumes the line idles high, so every stage resets to 1.
// edge_s is high for one cycle after the synchronised level changes.
module abr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic line_s,
    output logic edge_s
);
    logic [STAGES-1:0] pipe_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // One synchroniser stage, the first one fed from the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[g] <= 1'b1;
                else if (g == 0) pipe_q[g] <= din;
                else pipe_q[g] <= pipe_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    // Previous synchronised level, kept for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else prev_q <= pipe_q[STAGES-1];
    end

    assign line_s = pipe_q[STAGES-1];
    assign edge_s = pipe_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/abr_rate_quant.sv
// Combinational quantiser. It matches a measured bit period against the
// standard rate table. Assumes the tolerance bands of neighbouring rates
// do not overlap, which holds for TOL_SHIFT >= 2.
module abr_rate_quant #(
    parameter int unsigned CLK_HZ    = 3686400,
    parameter int unsigned BASE_RATE = 300,
    parameter int unsigned TOL_SHIFT = 3,
    parameter int          CNT_W     = 16
) (
    input  logic [CNT_W-1:0]        min_cnt,
    output logic                    hit,
    output abr_pkg::rate_code_t     code,
    output logic [CNT_W-1:0]        period
);
    import abr_pkg::*;

    logic [RATE_CNT-1:0] match;
    logic [CNT_W-1:0]    nom [RATE_CNT];

    genvar k;
    generate
        for (k = 0; k < RATE_CNT; k++) begin : g_rate
            localparam int unsigned NOM = nominal_cycles(CLK_HZ, BASE_RATE, k);
            localparam int unsigned TOL = NOM >> TOL_SHIFT;
            assign nom[k]   = CNT_W'(NOM);
            assign match[k] = (min_cnt >= CNT_W'(NOM - TOL)) && (min_cnt <= CNT_W'(NOM + TOL));
        end
    endgenerate

    // Select the rate whose band contains the measured period.
    always_comb begin
        hit    = 1'b0;
        code   = '0;
        period = nom[0];
        for (int i = RATE_CNT-1; i >= 0; i--) begin
            if (match[i]) begin
                hit    = 1'b1;
                code   = rate_code_t'(i);
                period = nom[i];
            end
        end
    end
endmodule

// File: rtl/abr_trainer.sv
// Training sequencer, which runs in five steps:
// 1. Wait for a long idle-high gap.
// 2. Time NUM_INTERVALS inter-transition intervals, keeping the shortest.
// 3. Quantise it through the rate quantiser.
// 4. Wait for a second quiet gap.
// 5. Lock.
// Assumes line_s and edge_s come from the synchroniser.
module abr_trainer #(
    parameter int          NUM_INTERVALS = 8,
    parameter int unsigned GAP_TRAIN_CYC = 1198080,
    parameter int unsigned GAP_DATA_CYC  = 147456,
    parameter int unsigned TIMEOUT       = 24576,
    parameter int          CNT_W         = 15,
    parameter int          GAP_W         = 21
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_s,
    input  logic                edge_s,
    input  logic                q_hit,
    input  abr_pkg::rate_code_t q_code,
    input  logic [CNT_W-1:0]    q_period,
    output logic [CNT_W-1:0]    min_cnt,
    output logic                locked,
    output abr_pkg::rate_code_t rate_code,
    output logic [CNT_W-1:0]    period
);
    import abr_pkg::*;

    localparam int IDX_W = $clog2(NUM_INTERVALS + 1);

    tr_state_e        state_q;
    logic [GAP_W-1:0] gap_q;
    logic [CNT_W-1:0] ivl_q;
    logic [CNT_W-1:0] ivl_len;
    logic [IDX_W-1:0] n_q;

    assign ivl_len = ivl_q + 1'b1;

    // Main training state machine with its gap, interval and minimum registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= TR_GAP1;
            gap_q     <= '0;
            ivl_q     <= '0;
            n_q       <= '0;
            min_cnt   <= '1;
            rate_code <= '0;
            period    <= '0;
        end else begin
            case (state_q)
                TR_GAP1: begin
                    if (!line_s || edge_s) gap_q <= '0;
                    else if (gap_q == GAP_W'(GAP_TRAIN_CYC - 1)) begin
                        state_q <= TR_ARMED;
                        gap_q   <= '0;
                    end else gap_q <= gap_q + 1'b1;
                end
                TR_ARMED: begin
                    if (edge_s) begin
                        state_q <= TR_MEAS;
                        ivl_q   <= '0;
                        n_q     <= '0;
                        min_cnt <= '1;
                    end
                end
                TR_MEAS: begin
                    if (edge_s) begin
                        if (ivl_len < min_cnt) min_cnt <= ivl_len;
                        ivl_q <= '0;
                        if (n_q == IDX_W'(NUM_INTERVALS - 1)) state_q <= TR_QUANT;
                        else n_q <= n_q + 1'b1;
                    end else if (ivl_q == CNT_W'(TIMEOUT - 1)) begin
                        state_q <= TR_GAP1;
                        gap_q   <= '0;
                    end else ivl_q <= ivl_len;
                end
                TR_QUANT: begin
                    gap_q <= '0;
                    if (q_hit) begin
                        rate_code <= q_code;
                        period    <= q_period;
                        state_q   <= TR_GAP2;
                    end else state_q <= TR_GAP1;
                end
                TR_GAP2: begin
                    if (!line_s || edge_s) gap_q <= '0;
                    else if (gap_q == GAP_W'(GAP_DATA_CYC - 1)) state_q <= TR_LOCK;
                    else gap_q <= gap_q + 1'b1;
                end
                default: state_q <= TR_LOCK;
            endcase
        end
    end

    assign locked = (state_q == TR_LOCK);
endmodule

// File: rtl/abr_bit_timer.sv
// Edge-resynchronised bit timer for the data phase.
// The phase counter returns to zero at every input transition and at the end
// of each nominal period. The clock is high during the first half of the
// period, and data is captured at the half-period point.
// Assumes period >= 2 and that it is stable while enable is high.
module abr_bit_timer #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             line_s,
    input  logic             edge_s,
    input  logic [CNT_W-1:0] period,
    output logic             bit_clk,
    output logic             bit_clk_n,
    output logic             data_out
);
    logic [CNT_W-1:0] phase_q;
    logic [CNT_W-1:0] phase_nx;
    logic [CNT_W-1:0] half;

    assign half = period >> 1;

    // Next phase: reloaded on a transition, wrapped at the end of the period.
    always_comb begin
        if (edge_s || (phase_q == period - 1'b1)) phase_nx = '0;
        else phase_nx = phase_q + 1'b1;
    end

    // Phase counter, output clock and mid-bit data capture.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase_q  <= '0;
            bit_clk  <= 1'b0;
            data_out <= 1'b1;
        end else begin
            phase_q <= phase_nx;
            bit_clk <= (phase_nx < half);
            if (phase_nx == half) data_out <= line_s;
        end
    end

    assign bit_clk_n = ~bit_clk;
endmodule

// File: rtl/autobaud_retimer.sv
// Top level of the autobaud retimer.
// It trains on an idle gap followed by a burst of transitions, then retimes
// the serial line with a recovered bit clock pair.
// Assumes the line idles high and the trainer sees one-bit intervals.
module autobaud_retimer #(
    parameter int unsigned CLK_HZ        = 3686400,
    parameter int unsigned BASE_RATE     = 300,
    parameter int unsigned TOL_SHIFT     = 3,
    parameter int          NUM_INTERVALS = 8,
    parameter int          SYNC_STAGES   = 2,
    parameter int unsigned GAP_TRAIN_CYC = 1198080,
    parameter int unsigned GAP_DATA_CYC  = 147456
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         serial_in,
    output logic                         data_out,
    output logic                         bit_clk,
    output logic                         bit_clk_n,
    output logic [abr_pkg::CODE_W-1:0]   rate_code,
    output logic                         locked
);
    import abr_pkg::*;

    localparam int unsigned SLOWEST = nominal_cycles(CLK_HZ, BASE_RATE, 0);
    localparam int unsigned TIMEOUT = 2 * SLOWEST;
    localparam int          CNT_W   = $clog2(TIMEOUT + 1);
    localparam int unsigned GAP_MAX = (GAP_TRAIN_CYC > GAP_DATA_CYC) ? GAP_TRAIN_CYC : GAP_DATA_CYC;
    localparam int          GAP_W   = $clog2(GAP_MAX + 1);

    logic             line_s;
    logic             edge_s;
    logic [CNT_W-1:0] min_cnt;
    logic             q_hit;
    rate_code_t       q_code;
    logic [CNT_W-1:0] q_period;
    logic [CNT_W-1:0] period;

    abr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(serial_in), .line_s(line_s), .edge_s(edge_s)
    );

    abr_rate_quant #(
        .CLK_HZ(CLK_HZ), .BASE_RATE(BASE_RATE), .TOL_SHIFT(TOL_SHIFT), .CNT_W(CNT_W)
    ) u_quant (
        .min_cnt(min_cnt), .hit(q_hit), .code(q_code), .period(q_period)
    );

    abr_trainer #(
        .NUM_INTERVALS(NUM_INTERVALS), .GAP_TRAIN_CYC(GAP_TRAIN_CYC),
        .GAP_DATA_CYC(GAP_DATA_CYC), .TIMEOUT(TIMEOUT), .CNT_W(CNT_W), .GAP_W(GAP_W)
    ) u_trainer (
        .clk(clk), .rst_n(rst_n), .line_s(line_s), .edge_s(edge_s),
        .q_hit(q_hit), .q_code(q_code), .q_period(q_period),
        .min_cnt(min_cnt), .locked(locked), .rate_code(rate_code), .period(period)
    );

    abr_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .enable(locked), .line_s(line_s), .edge_s(edge_s),
        .period(period), .bit_clk(bit_clk), .bit_clk_n(bit_clk_n), .data_out(data_out)
    );
endmodule

// File: rtl/abr_checker.sv
// Property checker for autobaud_retimer, attached through the bind below.
module abr_checker (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        locked,
    input logic [abr_pkg::CODE_W-1:0]  rate_code,
    input logic                        bit_clk,
    input logic                        data_out,
    input logic                        line_s
);
    import abr_pkg::*;

    AST_IDLE_BEFORE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (!bit_clk && data_out)); // R7

    AST_DOUT_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !$stable(data_out)) |-> $fell(bit_clk)); // R7

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked); // R6

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(rate_code)); // R6

    AST_LOCK_ON_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> (line_s && $past(line_s))); // R6

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (rate_code <= CODE_W'(RATE_CNT - 1))); // R4
endmodule

bind autobaud_retimer abr_checker i_abr_checker (
    .clk(clk), .rst_n(rst_n), .locked(locked), .rate_code(rate_code),
    .bit_clk(bit_clk), .data_out(data_out), .line_s(line_s)
);

// File: tb/test_autobaud_retimer.sv
// Scoreboard bench: the frame driver queues the bits it sends, and the monitor
// compares them against data_out at each falling edge of bit_clk.
module test_autobaud_retimer;
    localparam int          CLK_PERIOD = 10;
    localparam int unsigned T_CLK_HZ   = 76800;
    localparam int          GAP_T      = 600;
    localparam int          GAP_D      = 300;
    localparam int          WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       serial_in = 1'b1;
    logic       data_out, bit_clk, bit_clk_n, locked;
    logic [2:0] rate_code;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    bit   armed = 1'b0;
    logic prev_clk = 1'b0;
    logic exp_q[$];

    autobaud_retimer #(
        .CLK_HZ(T_CLK_HZ), .GAP_TRAIN_CYC(GAP_T), .GAP_DATA_CYC(GAP_D)
    ) i_autobaud_retimer (
        .clk(clk), .rst_n(rst_n), .serial_in(serial_in), .data_out(data_out),
        .bit_clk(bit_clk), .bit_clk_n(bit_clk_n), .rate_code(rate_code), .locked(locked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int bit_cycles(input int code);
        return int'(T_CLK_HZ / (300 << code));
    endfunction

    task automatic hold(input logic v, input int n);
        serial_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        serial_in = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Start bit, eight data bits LSB first, stop bit. One bit may be stretched.
    task automatic send_frame(input logic [7:0] b, input int p, input int sidx, input int s);
        logic [9:0] fr;
        fr = {1'b1, b, 1'b0};
        for (int i = 0; i < 10; i++) hold(fr[i], p + ((i == sidx) ? s : 0));
    endtask

    // A falling edge, then eight intervals of mult[i] bit times, then a return high.
    task automatic send_intervals(input int p, input int mult[8]);
        serial_in = 1'b0;
        for (int i = 0; i < 8; i++) begin
            repeat (mult[i] * p) @(negedge clk);
            serial_in = ~serial_in;
        end
        hold(1'b0, p);
        serial_in = 1'b1;
    endtask

    // Scoreboard driver: aligns to a bit_clk fall, queues the frame bits and sends them.
    task automatic sb_frame(input logic [7:0] b, input int p, input int sidx, input int s);
        logic [9:0] fr;
        logic lc;
        fr = {1'b1, b, 1'b0};
        lc = bit_clk;
        forever begin
            @(negedge clk);
            if (lc && !bit_clk) break;
            lc = bit_clk;
        end
        for (int i = 0; i < 10; i++) exp_q.push_back(fr[i]);
        serial_in = fr[0];
        @(negedge clk);
        armed = 1'b1;
        repeat (p - 1 + ((sidx == 0) ? s : 0)) @(negedge clk);
        for (int i = 1; i < 10; i++) hold(fr[i], p + ((i == sidx) ? s : 0));
        hold(1'b1, 2 * p);
        check(exp_q.size() == 0, "R7", "frame bits left unsampled", exp_q.size(), 0);
        exp_q.delete();
        armed = 1'b0;
    endtask

    task automatic expect_lock(input int code, input string req);
        check(locked == 1'b1, req, "locked after quiet gap", locked, 1);
        check(rate_code == 3'(code), req, "rate code", rate_code, code);
    endtask

    // Monitor: at each bit_clk fall, compare data_out with the next queued bit.
    always @(negedge clk) begin
        if (armed && prev_clk && !bit_clk && exp_q.size() > 0) begin
            logic e;
            e = exp_q.pop_front();
            check(data_out == e, "R8", "retimed bit at mid-bit", data_out, e);
            check(bit_clk_n == ~bit_clk, "R7", "complement clock", bit_clk_n, ~bit_clk);
        end
        prev_clk = bit_clk;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        check(locked == 1'b0, "R1", "locked", locked, 0);
        check(rate_code == 3'd0, "R1", "rate_code", rate_code, 0);
        check(bit_clk == 1'b0, "R1", "bit_clk", bit_clk, 0);
        check(bit_clk_n == 1'b1, "R1", "bit_clk_n", bit_clk_n, 1);
        check(data_out == 1'b1, "R1", "data_out", data_out, 1);

        // R2: a 9600 character after too short a gap is ignored; 2400 training then locks.
        hold(1'b1, GAP_T / 2);
        send_frame(8'h55, bit_cycles(5), -1, 0);
        hold(1'b1, GAP_T + 20);
        send_frame(8'h55, bit_cycles(3), -1, 0);
        hold(1'b1, 100);
        check(locked == 1'b0, "R6", "locked during quiet gap", locked, 0);
        hold(1'b1, GAP_D);
        expect_lock(3, "R2");

        // R7 plain frame, R8 slow sender and a delayed edge
        sb_frame(8'hA7, bit_cycles(3), -1, 0);
        sb_frame(8'h55, bit_cycles(3) + 4, -1, 0);
        sb_frame(8'hA7, bit_cycles(3), 3, 8);
        expect_lock(3, "R6");

        // R5: an out-of-band period is rejected; R3: the minimum of mixed intervals is used.
        do_reset();
        hold(1'b1, GAP_T + 20);
        send_frame(8'h55, 22, -1, 0);
        hold(1'b1, 2 * GAP_D + 50);
        check(locked == 1'b0, "R5", "locked after rejected rate", locked, 0);
        check(bit_clk == 1'b0 && data_out == 1'b1, "R7", "outputs idle before lock",
              {bit_clk, data_out}, 1);
        hold(1'b1, GAP_T + 20);
        send_intervals(bit_cycles(2), '{3, 2, 1, 2, 3, 2, 2, 2});
        hold(1'b1, GAP_D + 50);
        expect_lock(2, "R3");
        sb_frame(8'h96, bit_cycles(2), -1, 0);

        // R5: an over-long interval aborts training; slowest rate trains afterwards.
        do_reset();
        hold(1'b1, GAP_T + 20);
        hold(1'b0, 600);
        hold(1'b1, 150);
        check(locked == 1'b0, "R5", "locked after interval timeout", locked, 0);
        hold(1'b1, GAP_T);
        send_frame(8'h55, bit_cycles(0), -1, 0);
        hold(1'b1, GAP_D + 50);
        expect_lock(0, "R5");
        sb_frame(8'h5A, bit_cycles(0), -1, 0);

        // R4: fastest rate
        do_reset();
        hold(1'b1, GAP_T + 20);
        send_frame(8'h55, bit_cycles(5), -1, 0);
        hold(1'b1, GAP_D + 50);
        expect_lock(5, "R4");
        sb_frame(8'h3C, bit_cycles(5), -1, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule